// File: doc/BRIEF.md
# Gated Timer with Full-Period Toggle Gate

The block is a 16-bit up-counter whose advance is controlled by a gate. The gate level comes from either an external pin or a one-cycle overflow pulse produced by a neighbouring timer. A polarity control selects which level of that source opens the gate. Software can also turn gating off so that the counter advances on every enabled clock.

In toggle mode, the selected gate passes through a flip-flop. The flip-flop changes state on every edge where the gate becomes active. The counter then runs for one whole gate period rather than for only the active phase. The flip-flop is forced low and held there whenever toggle mode or the timer enable is off. This means the first active-going edge after re-enabling always opens the window.

Single-pulse mode lets the counter measure exactly one window. A go request arms the measurement, and counting happens only inside the first window that starts after arming. When that window closes, the armed flag clears and a one-cycle gate-event pulse is raised. Single-pulse mode works together with toggle mode, so the block can measure exactly one full period.

The single-pulse controller has three states:
- `SP_IDLE` to `SP_WAIT`: a go request arrives while the timer and single-pulse mode are enabled.
- `SP_WAIT` to `SP_OPEN`: the staged gate rises.
- `SP_OPEN` to `SP_IDLE`: the staged gate falls, which also raises the event.
- Any state to `SP_IDLE`: the timer enable or single-pulse mode is dropped.

Top module: `gated_timer`

## Requirements
- R1: After reset, `count` is 0 and `ovf`, `gate_evt` and `armed` are 0.
- R2: With `run_en`=1 and `gate_on`=0, `count` increments by one on every clock. With `run_en`=0, `count` holds its value.
- R3: With `gate_on`=1, `gate_src`=0 selects `gate_pin` and `gate_src`=1 selects `peer_ovf`. The unselected source has no effect on counting. `count` advances only on clocks where the effective gate `gate_val` is 1.
- R4: `gate_pol`=1 makes a high source level active, and `gate_pol`=0 makes a low level active.
- R5: With `toggle_on`=1, the gate flip-flop inverts on each clock where the polarity-adjusted source goes from inactive to active. Two such edges P clocks apart advance `count` by exactly P, whatever the pulse width.
- R6: While `toggle_on`=0 or `run_en`=0, the toggle flip-flop is cleared and held clear. After re-enabling, `count` does not advance until a new active-going edge arrives.
- R7: A one-cycle `go_set` while `run_en`=1 and `single_on`=1 sets `armed` on the next clock. A `go_set` while `single_on`=0 leaves `armed` at 0.
- R8: In single-pulse mode, counting happens only from the first rise of the staged gate after arming until that gate falls. A window already open when arming does not count. When the window closes, `armed` returns to 0 and `gate_evt` is 1 for exactly one clock.
- R9: Single-pulse mode with toggle mode counts exactly one full gate period P. Later edges do not advance `count`.
- R10: `count` wraps from 0xFFFF to 0, and `ovf` is 1 for exactly the one clock after that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Timer enable |
| gate_on | input | 1 | 1 = counting is gated, 0 = free-running |
| gate_src | input | 1 | Gate source select: 0 pin, 1 peer overflow |
| gate_pin | input | 1 | External gate level |
| peer_ovf | input | 1 | One-cycle overflow pulse from another timer |
| gate_pol | input | 1 | 1 = high level active, 0 = low level active |
| toggle_on | input | 1 | Toggle (full-period) mode enable |
| single_on | input | 1 | Single-pulse mode enable |
| go_set | input | 1 | Pulse that arms a single-pulse measurement |
| count | output | 16 | Counter value |
| ovf | output | 1 | One-clock pulse after a wrap to zero |
| gate_val | output | 1 | Effective gate currently admitting counts |
| gate_evt | output | 1 | One-clock pulse when a single-pulse window closes |
| armed | output | 1 | Single-pulse measurement pending or in progress |

## Verification
The bench sweeps toggle-mode period and pulse width over small ranges and expects the count to equal the period for every width. A flip-flop that counted only the active phase, or counted on both edges, would return the width or half the period instead. It drops the enable, and separately toggle mode, while the flip-flop is set. A design that failed to clear the flip-flop would then keep counting with no new edge. Single-pulse checks cover:
- arming while the gate is already open, where a wrong design counts a partial window;
- a run of several gate periods after one arm, where a wrong design counts more than one period or misses the event pulse.

A long free run checks the wrap at 0xFFFF and the single-clock overflow pulse.

// File: rtl/gated_timer_pkg.sv
package gated_timer_pkg;
    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_WAIT = 2'd1,
        SP_OPEN = 2'd2
    } sp_state_t;
endpackage

// File: rtl/gt_gate_path.sv
// Source select, polarity and the full-period toggle flip-flop.
module gt_gate_path (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic gate_src,
    input  logic gate_pin,
    input  logic peer_ovf,
    input  logic gate_pol,
    input  logic toggle_on,
    output logic stage,
    output logic stage_rise
);
    logic raw_lvl;
    logic act_lvl;
    logic act_q;
    logic tog_q;
    logic stage_q;
    logic act_rise;

    always_comb begin
        raw_lvl  = gate_src ? peer_ovf : gate_pin;
        act_lvl  = gate_pol ? raw_lvl : ~raw_lvl;
        act_rise = act_lvl & ~act_q;
        stage    = toggle_on ? tog_q : act_lvl;
        stage_rise = stage & ~stage_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            tog_q   <= 1'b0;
            stage_q <= 1'b0;
        end else begin
            act_q   <= act_lvl;
            stage_q <= stage;
            if (!toggle_on || !run_en)
                tog_q <= 1'b0;
            else if (act_rise)
                tog_q <= ~tog_q;
        end
    end

    // R6: flip-flop forced clear while toggle mode or enable is off
    a_r6_toggle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_on || !run_en) |=> !tog_q);

    // R5: flip-flop inverts on each active-going edge
    a_r5_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_on && run_en && act_rise) |=> (tog_q != $past(tog_q)));

    // R5: without an active-going edge the flip-flop keeps its state
    a_r5_toggle_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_on && run_en && !act_rise) |=> $stable(tog_q));
endmodule

// File: rtl/gt_pulse_fsm.sv
// Single-pulse window controller.
module gt_pulse_fsm
    import gated_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic single_on,
    input  logic go_set,
    input  logic stage,
    input  logic stage_rise,
    output logic win_open,
    output logic armed,
    output logic gate_evt
);
    sp_state_t st;
    sp_state_t st_nxt;

    always_comb begin
        st_nxt = st;
        if (!run_en || !single_on) begin
            st_nxt = SP_IDLE;
        end else begin
            unique case (st)
                SP_IDLE: if (go_set)     st_nxt = SP_WAIT;
                SP_WAIT: if (stage_rise) st_nxt = SP_OPEN;
                SP_OPEN: if (!stage)     st_nxt = SP_IDLE;
                default:                 st_nxt = SP_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SP_IDLE;
        else        st <= st_nxt;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_evt <= 1'b0;
        else
            gate_evt <= run_en && single_on && (st == SP_OPEN) && !stage;
    end

    always_comb begin
        armed    = (st != SP_IDLE);
        win_open = stage && ((st == SP_OPEN) || ((st == SP_WAIT) && stage_rise));
    end

    // R7: go request while enabled arms the measurement
    a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && single_on && !armed && go_set) |=> armed);

    // R7: disabling the mode disarms
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en || !single_on) |=> !armed);

    // R8: window close raises event and disarms
    a_r8_close: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && single_on && st == SP_OPEN && !stage) |=> (gate_evt && !armed));

    // R8: event is a single-clock pulse
    a_r8_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        gate_evt |=> !gate_evt);
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= inc && (count == TOP);
            if (inc) count <= count + 1'b1;
        end
    end

    // R10: wrap to zero with overflow pulse
    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count == TOP) |=> (count == '0 && ovf));

    // R10: overflow only after a wrap
    a_r10_ovf_only_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && count == TOP) |=> !ovf);

    // R2: no advance without an increment
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/gated_timer.sv
module gated_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         gate_on,
    input  logic         gate_src,
    input  logic         gate_pin,
    input  logic         peer_ovf,
    input  logic         gate_pol,
    input  logic         toggle_on,
    input  logic         single_on,
    input  logic         go_set,
    output logic [W-1:0] count,
    output logic         ovf,
    output logic         gate_val,
    output logic         gate_evt,
    output logic         armed
);
    logic stage;
    logic stage_rise;
    logic win_open;
    logic inc;

    gt_gate_path u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .gate_src   (gate_src),
        .gate_pin   (gate_pin),
        .peer_ovf   (peer_ovf),
        .gate_pol   (gate_pol),
        .toggle_on  (toggle_on),
        .stage      (stage),
        .stage_rise (stage_rise)
    );

    gt_pulse_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .single_on  (single_on),
        .go_set     (go_set),
        .stage      (stage),
        .stage_rise (stage_rise),
        .win_open   (win_open),
        .armed      (armed),
        .gate_evt   (gate_evt)
    );

    always_comb begin
        gate_val = single_on ? win_open : stage;
        inc      = run_en && (!gate_on || gate_val);
    end

    gt_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .count (count),
        .ovf   (ovf)
    );

    // R3: gated counting advances only while the gate admits counts
    a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !gate_val) |=> $stable(count));
endmodule

// File: tb/gated_timer_test.sv
module gated_timer_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 0, gate_on = 0, gate_src = 0, gate_pin = 0, peer_ovf = 0;
    logic gate_pol = 1, toggle_on = 0, single_on = 0, go_set = 0;
    logic [15:0] count;
    logic ovf, gate_val, gate_evt, armed;

    int total = 0;
    int bad = 0;
    int evt_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_timer uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_on(gate_on),
        .gate_src(gate_src), .gate_pin(gate_pin), .peer_ovf(peer_ovf),
        .gate_pol(gate_pol), .toggle_on(toggle_on), .single_on(single_on),
        .go_set(go_set), .count(count), .ovf(ovf), .gate_val(gate_val),
        .gate_evt(gate_evt), .armed(armed)
    );

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && gate_evt) evt_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive selected source to active (1) or inactive (0) level under current polarity
    task automatic line(input bit src, input bit act);
        logic v;
        v = gate_pol ? act : ~act;
        if (src) peer_ovf = v;
        else     gate_pin = v;
    endtask

    task automatic idle_lines();
        line(1'b0, 1'b0);
        line(1'b1, 1'b0);
    endtask

    task automatic rearm_toggle();
        toggle_on = 0;
        idle_lines();
        cyc(2);
        toggle_on = 1;
        cyc(1);
    endtask

    // two active-going edges p clocks apart, each active w clocks
    task automatic two_edges(input bit src, input int p, input int w);
        line(src, 1); cyc(w); line(src, 0); cyc(p - w);
        line(src, 1); cyc(w); line(src, 0);
    endtask

    initial begin
        logic [15:0] c0;
        logic [15:0] d;
        int e0;

        cyc(3);
        // R1: reset values
        chk("R1 count", count, 0);
        chk("R1 ovf/evt/armed", {ovf, gate_evt, armed}, 0);
        rst_n = 1;
        cyc(1);

        // R2: free run and hold
        run_en = 1; gate_on = 0;
        c0 = count; cyc(10); d = count - c0;
        chk("R2 free run", d, 10);
        run_en = 0; c0 = count; cyc(5); d = count - c0;
        chk("R2 hold when disabled", d, 0);
        run_en = 1;

        // R3/R4: plain gating, both polarities, sweep of lengths
        gate_on = 1;
        for (int pol = 1; pol >= 0; pol--) begin
            gate_pol = pol[0];
            idle_lines();
            cyc(1);
            for (int n = 1; n <= 8; n++) begin
                c0 = count;
                line(0, 1); #1;
                chk("R3 gate_val open", gate_val, 1);
                cyc(n); line(0, 0); #1;
                chk("R3 gate_val closed", gate_val, 0);
                cyc(3); d = count - c0;
                chk(pol ? "R4 high-active count" : "R4 low-active count", d, n);
            end
        end
        gate_pol = 1; idle_lines(); cyc(1);

        // R3: peer source selected, pin wiggle ignored
        gate_src = 1; c0 = count;
        for (int k = 0; k < 6; k++) begin gate_pin = ~gate_pin; cyc(1); end
        gate_pin = 0; d = count - c0;
        chk("R3 unselected pin ignored", d, 0);
        c0 = count; peer_ovf = 1; cyc(4); peer_ovf = 0; cyc(2); d = count - c0;
        chk("R3 peer source count", d, 4);
        gate_src = 0;

        // R5: toggle sweep over period and width, pin source
        for (int p = 2; p <= 9; p++) begin
            for (int w = 1; w < p; w++) begin
                rearm_toggle();
                c0 = count; two_edges(0, p, w); cyc(4); d = count - c0;
                chk("R5 toggle pin full period", d, p);
            end
        end
        // R5: toggle with peer overflow pulses
        gate_src = 1;
        for (int p = 2; p <= 9; p++) begin
            rearm_toggle();
            c0 = count; two_edges(1, p, 1); cyc(4); d = count - c0;
            chk("R5 toggle peer full period", d, p);
        end
        gate_src = 0;
        // R5 with low-active polarity
        gate_pol = 0;
        rearm_toggle();
        c0 = count; two_edges(0, 6, 2); cyc(4); d = count - c0;
        chk("R5 toggle low-active", d, 6);
        gate_pol = 1;

        // R6: enable drop clears the flip-flop
        rearm_toggle();
        line(0, 1); cyc(1); line(0, 0); cyc(3);
        run_en = 0; c0 = count; cyc(3);
        chk("R2 hold with toggle open", count, c0);
        run_en = 1; cyc(8);
        chk("R6 enable drop clears toggle", count, c0);
        // R6: toggle mode drop clears the flip-flop
        line(0, 1); cyc(1); line(0, 0); cyc(2);
        toggle_on = 0; cyc(2); toggle_on = 1; c0 = count; cyc(8); d = count - c0;
        chk("R6 toggle drop clears toggle", d, 0);
        toggle_on = 0;

        // R7: go ignored while single-pulse off
        single_on = 0; go_set = 1; cyc(1); go_set = 0; cyc(1);
        chk("R7 go ignored", armed, 0);

        // R8: single-pulse window, pin level
        single_on = 1; cyc(1);
        e0 = evt_cnt; c0 = count;
        go_set = 1; cyc(1); go_set = 0;
        chk("R7 armed after go", armed, 1);
        cyc(3);
        d = count - c0; chk("R8 no count while waiting", d, 0);
        line(0, 1); cyc(5); line(0, 0); cyc(3);
        d = count - c0; chk("R8 window count", d, 5);
        chk("R8 disarmed", armed, 0);
        chk("R8 one event", evt_cnt - e0, 1);
        line(0, 1); cyc(4); line(0, 0); cyc(2);
        d = count - c0; chk("R8 later window ignored", d, 5);

        // R8: arming inside an open window does not count it
        line(0, 1); cyc(2);
        c0 = count; e0 = evt_cnt;
        go_set = 1; cyc(1); go_set = 0; cyc(3);
        d = count - c0; chk("R8 partial window skipped", d, 0);
        line(0, 0); cyc(2); line(0, 1); cyc(3); line(0, 0); cyc(3);
        d = count - c0; chk("R8 next full window", d, 3);
        chk("R8 event after window", evt_cnt - e0, 1);

        // R9: single pulse plus toggle, pin and peer sources
        for (int s = 0; s < 2; s++) begin
            gate_src = s[0];
            rearm_toggle();
            c0 = count; e0 = evt_cnt;
            go_set = 1; cyc(1); go_set = 0; cyc(1);
            for (int k = 0; k < 3; k++) begin
                line(s[0], 1); cyc(1); line(s[0], 0); cyc(6);
            end
            cyc(4);
            d = count - c0; chk("R9 one full period", d, 7);
            chk("R9 event once", evt_cnt - e0, 1);
            chk("R9 disarmed", armed, 0);
        end
        gate_src = 0; toggle_on = 0; single_on = 0;

        // R10: wrap and overflow pulse
        gate_on = 0; cyc(1);
        c0 = count;
        cyc(16'hFFFF - c0);
        chk("R10 reaches max", count, 16'hFFFF);
        chk("R10 no early ovf", ovf, 0);
        cyc(1);
        chk("R10 wraps to zero", count, 0);
        chk("R10 ovf pulse", ovf, 1);
        cyc(1);
        chk("R10 ovf one clock", ovf, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule